// File: doc/BRIEF.md
# Multichannel Polyphase Fractional Resampler

This block changes the sample rate of interleaved real I and Q streams ahead of a quantizer by a fractional ratio L/M (default 3/4). Samples arrive one per accepted cycle in a fixed channel rotation, so one set of CH samples (one per channel) forms a frame. Every channel keeps its own tap history. For each output only the coefficient branch of the current polyphase phase is applied. This keeps the work per output at TAPS products instead of L*TAPS.

One datapath is shared round-robin across the eight channels of a lane. LANES lanes (default four) run side by side and share one channel pointer and one phase accumulator, so four lanes of eight channels cover 32 real channels. Outputs leave one cycle after the input that produced them. They carry the same channel order, with a valid strobe, the channel label and the phase used. The ratio, tap count, word widths and the rounding shift are parameters. The ratio must satisfy M >= L.

Top module: `mc_frac_resampler`

## Requirements
- R1: While rst_n is low, out_valid is low. After reset the first accepted sample goes to channel 0, every tap history holds zero, and the first output frame uses phase 0.
- R2: Accepted samples are assigned to channels 0,1,...,CH-1 in rotation (CH=8). Outputs appear in that same order, and out_chan carries the channel index of each output.
- R3: Count frames from reset starting at 0, and count output frames the same way with index n. Frame f produces outputs if and only if some n satisfies floor(n*M/L) = f. With 3/4 this means frames 0, 1 and 2 emit, frame 3 does not, and the pattern repeats. After F complete frames, ceil(F*L/M) frames have produced outputs.
- R4: Output frame n uses phase p = (n*M) mod L. This phase is shown on out_phase and is the same for every channel of the frame.
- R5: The output of channel c is y = sum over k=0..TAPS-1 of h[k*L+p] * x_c(k). Here x_c(0) is the sample just accepted for c, x_c(k) is the k-th earlier sample of that same channel, TAPS=4, and h[j] = 97*(j+1)*(L*TAPS-j) - 2000. The sum is formed at full precision.
- R6: A sample fed to one channel changes no other channel's outputs.
- R7: The full-precision sum is rounded half-up: 2^(SHIFT-1) is added, then the result is shifted right arithmetically by SHIFT (SHIFT=11).
- R8: The rounded value is saturated to the signed 16-bit range [-32768, 32767].
- R9: An output appears in the cycle after the clock edge that accepted its input. A cycle with in_valid low produces no output, advances neither the channel nor the phase, and leaves every history unchanged, whatever is on in_data.
- R10: Lane l occupies bits [16*l+15 : 16*l] of both in_data and out_data. The lanes share channel and phase, and each lane filters only its own histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept one sample per lane for the current channel |
| in_data | input | LANES*16 | Signed input samples, one per lane |
| out_valid | output | 1 | Output samples valid |
| out_chan | output | 3 | Channel index of the outputs |
| out_phase | output | 2 | Polyphase branch used for the outputs |
| out_data | output | LANES*16 | Signed, rounded and saturated outputs, one per lane |

## Verification
The bench goes after the frame-skip pattern of the 3/4 ratio. A design with a wrong phase step emits in the skipped frame or drops a frame, and the total output count drifts from ceil(F*L/M). Two tests check separation. An impulse in a single channel of a single lane shows a leak across channels or lanes as nonzero output where only zero is allowed, and a history shifted in the wrong order pairs a coefficient with the wrong age of sample. Small inputs expose rounding toward zero or truncation as errors of one. Full-scale inputs of both signs show wrap-around where clamping is required. Gaps filled with junk on in_data catch a design that shifts a history or advances the channel on an idle cycle.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

    // Prototype coefficient generator: a shifted parabola over the full
    // polyphase set, negative at both ends so sign handling is exercised.
    function automatic int coef_value(input int idx, input int ntot);
        return 97 * (idx + 1) * (ntot - idx) - 2000;
    endfunction

endpackage

// File: rtl/rsmp_phase_ctrl.sv
module rsmp_phase_ctrl #(
    parameter int CH = 8,
    parameter int L  = 3,
    parameter int M  = 4,
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
    localparam int PW  = (L > 1) ? $clog2(L) : 1,
    localparam int AW  = $clog2(2 * M + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic [CHW-1:0] chan,
    output logic           emit,
    output logic [PW-1:0]  phase
);

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic [AW-1:0]  acc;   // n*M - m*L, always in [0, M)
    } ctrl_t;

    ctrl_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        emit = (s_q.acc < AW'(L));
        if (in_valid) begin
            if (s_q.ch == CHW'(CH - 1)) begin
                s_d.ch  = '0;
                s_d.acc = emit ? (s_q.acc + AW'(M) - AW'(L)) : (s_q.acc - AW'(L));
            end else begin
                s_d.ch = s_q.ch + CHW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign chan  = s_q.ch;
    assign phase = PW'(s_q.acc);

endmodule

// File: rtl/rsmp_tap_store.sv
module rsmp_tap_store #(
    parameter int CH   = 8,
    parameter int TAPS = 4,
    parameter int DW   = 16,
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
    localparam int HL  = TAPS - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [CHW-1:0]            chan,
    input  logic [DW-1:0]             din,
    output logic [TAPS-1:0][DW-1:0]   taps
);

    typedef logic [HL-1:0][DW-1:0] line_t;

    typedef struct packed {
        line_t [CH-1:0] hist;
    } store_t;

    store_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        taps[0] = din;
        for (int k = 1; k < TAPS; k++) begin
            taps[k] = s_q.hist[chan][k-1];
        end
        if (wr_en) begin
            s_d.hist[chan][0] = din;
            for (int k = 1; k < HL; k++) begin
                s_d.hist[chan][k] = s_q.hist[chan][k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rsmp_mac.sv
module rsmp_mac #(
    parameter int L     = 3,
    parameter int TAPS  = 4,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int SHIFT = 11,
    localparam int PW   = (L > 1) ? $clog2(L) : 1,
    localparam int NC   = L * TAPS,
    localparam int ACCW = DW + CW + $clog2(TAPS) + 1
) (
    input  logic [TAPS-1:0][DW-1:0] taps,
    input  logic [PW-1:0]           phase,
    output logic [DW-1:0]           y
);

    localparam logic signed [ACCW-1:0] HALF    = ACCW'(1) << (SHIFT - 1);
    localparam logic signed [ACCW-1:0] POS_LIM = (ACCW'(1) << (DW - 1)) - ACCW'(1);
    localparam logic signed [ACCW-1:0] NEG_LIM = -POS_LIM - ACCW'(1);

    logic signed [CW-1:0] coef_rom [NC];

    for (genvar j = 0; j < NC; j++) begin : g_rom
        assign coef_rom[j] = CW'(rsmp_pkg::coef_value(j, NC));
    end

    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] rnd;
    logic signed [ACCW-1:0] shifted;

    always_comb begin
        logic signed [ACCW-1:0] c_ext;
        logic signed [ACCW-1:0] x_ext;
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            c_ext = ACCW'(coef_rom[k * L + int'(phase)]);
            x_ext = ACCW'($signed(taps[k]));
            acc   = acc + c_ext * x_ext;
        end
        rnd     = acc + HALF;
        shifted = rnd >>> SHIFT;
        if (shifted > POS_LIM)      y = DW'(POS_LIM);
        else if (shifted < NEG_LIM) y = DW'(NEG_LIM);
        else                        y = DW'(shifted);
    end

endmodule

// File: rtl/mc_frac_resampler.sv
module mc_frac_resampler #(
    parameter int LANES = 4,
    parameter int CH    = 8,
    parameter int L     = 3,
    parameter int M     = 4,
    parameter int TAPS  = 4,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int SHIFT = 11,
    localparam int CHW  = (CH > 1) ? $clog2(CH) : 1,
    localparam int PW   = (L > 1) ? $clog2(L) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    output logic                  out_valid,
    output logic [CHW-1:0]        out_chan,
    output logic [PW-1:0]         out_phase,
    output logic [LANES*DW-1:0]   out_data
);

    logic [CHW-1:0]             cur_chan;
    logic [PW-1:0]              cur_phase;
    logic                       cur_emit;
    logic [LANES-1:0][DW-1:0]   lane_y;

    rsmp_phase_ctrl #(.CH(CH), .L(L), .M(M)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .chan     (cur_chan),
        .emit     (cur_emit),
        .phase    (cur_phase)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAPS-1:0][DW-1:0] lane_taps;

        rsmp_tap_store #(.CH(CH), .TAPS(TAPS), .DW(DW)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (in_valid),
            .chan  (cur_chan),
            .din   (in_data[g*DW +: DW]),
            .taps  (lane_taps)
        );

        rsmp_mac #(.L(L), .TAPS(TAPS), .DW(DW), .CW(CW), .SHIFT(SHIFT)) u_mac (
            .taps  (lane_taps),
            .phase (cur_phase),
            .y     (lane_y[g])
        );
    end

    typedef struct packed {
        logic                     valid;
        logic [CHW-1:0]           chan;
        logic [PW-1:0]            phase;
        logic [LANES-1:0][DW-1:0] data;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid & cur_emit;
        if (in_valid && cur_emit) begin
            o_d.chan  = cur_chan;
            o_d.phase = cur_phase;
            o_d.data  = lane_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_chan  = o_q.chan;
    assign out_phase = o_q.phase;
    assign out_data  = o_q.data;

endmodule

// File: rtl/rsmp_checker.sv
module rsmp_checker #(
    parameter int CH = 8,
    parameter int L  = 3,
    parameter int M  = 4,
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
    localparam int PW  = (L > 1) ? $clog2(L) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           out_valid,
    input logic [CHW-1:0] out_chan,
    input logic [PW-1:0]  out_phase
);

    localparam int STEP = M % L;

    logic [CHW-1:0] nxt_ch_q;
    logic [PW-1:0]  frame_ph_q;
    logic           seen_q;
    logic [PW-1:0]  next_ph;

    always_comb begin
        int t;
        t = int'(frame_ph_q) + STEP;
        if (t >= L) t = t - L;
        next_ph = PW'(t);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_ch_q   <= '0;
            frame_ph_q <= '0;
            seen_q     <= 1'b0;
        end else if (out_valid) begin
            nxt_ch_q <= (out_chan == CHW'(CH - 1)) ? '0 : out_chan + CHW'(1);
            if (out_chan == '0) begin
                frame_ph_q <= out_phase;
                seen_q     <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) p_reset_quiet_r1: assert (!out_valid);
    end

    p_first_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chan == '0 && !seen_q) |-> (out_phase == '0));

    p_chan_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan == nxt_ch_q));

    p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_phase) < L));

    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chan != '0) |-> (out_phase == frame_ph_q));

    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chan == '0 && seen_q) |-> (out_phase == next_ph));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind mc_frac_resampler rsmp_checker #(.CH(CH), .L(L), .M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_phase (out_phase)
);

// File: tb/mc_frac_resampler_bench.sv
`timescale 1ns/1ps
module mc_frac_resampler_bench;

    localparam int LANES = 4, CH = 8, L = 3, M = 4, TAPS = 4, DW = 16, SHIFT = 11;
    localparam int NC = L * TAPS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [LANES*DW-1:0] in_data = '0;
    logic                out_valid;
    logic [2:0]          out_chan;
    logic [1:0]          out_phase;
    logic [LANES*DW-1:0] out_data;

    always #2.5 clk = ~clk;

    mc_frac_resampler #(.LANES(LANES), .CH(CH), .L(L), .M(M), .TAPS(TAPS),
                        .DW(DW), .SHIFT(SHIFT)) u_mc_frac_resampler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_phase(out_phase),
        .out_data(out_data)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    int hist [LANES][CH][TAPS];
    int bch = 0, frame = 0, nout = 0, frame_ph = 0, out_frames = 0;
    bit frame_emit = 0;
    bit exp_v = 0, last_in_v = 0;
    int exp_ch = 0, exp_ph = 0;
    int exp_d [LANES];
    bit exp_sat [LANES];
    string tag = "R1";
    int unsigned seed = 32'h2468_ACE1;

    function automatic int hcoef(int j);
        return 97 * (j + 1) * (NC - j) - 2000;
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[31:16]));
    endfunction

    task automatic check_outputs();
        total++;
        if (out_valid !== exp_v) begin
            bad++;
            $display("FAIL %s: out_valid=%0b expected %0b", last_in_v ? "R3" : "R9", out_valid, exp_v);
        end
        if (out_valid === 1'b1 && out_chan == 3'd0) out_frames++;
        if (exp_v) begin
            total++;
            if (out_chan !== 3'(exp_ch)) begin
                bad++;
                $display("FAIL R2: out_chan=%0d expected %0d", out_chan, exp_ch);
            end
            total++;
            if (out_phase !== 2'(exp_ph)) begin
                bad++;
                $display("FAIL R4: out_phase=%0d expected %0d", out_phase, exp_ph);
            end
            for (int l = 0; l < LANES; l++) begin
                int got;
                got = int'($signed(out_data[l*DW +: DW]));
                total++;
                if (got != exp_d[l]) begin
                    bad++;
                    $display("FAIL %s: lane %0d chan %0d data=%0d expected %0d",
                             exp_sat[l] ? "R8" : tag, l, exp_ch, got, exp_d[l]);
                end
            end
        end
    endtask

    task automatic step(input bit v, input int d [LANES]);
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        last_in_v = v;
        exp_v     = 1'b0;
        if (!v) begin
            for (int l = 0; l < LANES; l++) in_data[l*DW +: DW] = DW'(rnd16());
        end else begin
            if (bch == 0) begin
                frame_emit = ((nout * M) / L == frame);
                frame_ph   = (nout * M) % L;
            end
            for (int l = 0; l < LANES; l++) begin
                longint acc, r;
                in_data[l*DW +: DW] = DW'(d[l]);
                for (int k = TAPS - 1; k > 0; k--) hist[l][bch][k] = hist[l][bch][k-1];
                hist[l][bch][0] = d[l];
                acc = 0;
                for (int k = 0; k < TAPS; k++)
                    acc += longint'(hcoef(k * L + frame_ph)) * longint'(hist[l][bch][k]);
                r = (acc + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
                exp_sat[l] = 1'b0;
                if (r > 32767)       begin r = 32767;  exp_sat[l] = 1'b1; end
                else if (r < -32768) begin r = -32768; exp_sat[l] = 1'b1; end
                exp_d[l] = int'(r);
            end
            if (frame_emit) begin
                exp_v  = 1'b1;
                exp_ch = bch;
                exp_ph = frame_ph;
            end
            if (bch == CH - 1) begin
                bch = 0;
                frame++;
                if (frame_emit) nout++;
            end else begin
                bch++;
            end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        int z [LANES];
        int d [LANES];
        foreach (z[i]) z[i] = 0;
        for (int l = 0; l < LANES; l++)
            for (int c = 0; c < CH; c++)
                for (int k = 0; k < TAPS; k++) hist[l][c][k] = 0;

        // R1: quiet during reset
        repeat (4) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R1: out_valid=%0b during reset expected 0", out_valid);
            end
        end
        rst_n = 1'b1;

        // R6 and R1: single impulse in lane 0, channel 3, first frame after reset
        tag = "R6";
        for (int f = 0; f < 8; f++)
            for (int c = 0; c < CH; c++) begin
                d = z;
                if (f == 0 && c == 3) d[0] = 1000;
                step(1'b1, d);
            end

        // R5: moderate random samples, back to back
        tag = "R5";
        for (int i = 0; i < 40 * CH; i++) begin
            for (int l = 0; l < LANES; l++) d[l] = rnd16() % 4000;
            step(1'b1, d);
        end

        // R7: tiny samples where the rounding step decides the result
        tag = "R7";
        for (int i = 0; i < 40 * CH; i++) begin
            for (int l = 0; l < LANES; l++) d[l] = rnd16() % 8;
            step(1'b1, d);
        end

        // R8: full scale of both signs, lanes differ
        tag = "R8";
        for (int f = 0; f < 24; f++)
            for (int c = 0; c < CH; c++) begin
                d[0] = 32767;  d[1] = (f % 6 < 3) ? 32767 : -32768;
                d[2] = -32768; d[3] = (c % 2 == 0) ? 32767 : -32768;
                step(1'b1, d);
            end

        // R9 and R10: full-range distinct lanes with idle gaps carrying junk
        tag = "R10";
        for (int i = 0; i < 60 * CH; i++) begin
            while ((rnd16() & 3) == 0) step(1'b0, z);
            for (int l = 0; l < LANES; l++) d[l] = rnd16();
            step(1'b1, d);
        end

        step(1'b0, z);
        step(1'b0, z);

        // R3: total number of emitting frames
        total++;
        if (out_frames != (frame * L + M - 1) / M) begin
            bad++;
            $display("FAIL R3: output frames=%0d expected %0d", out_frames, (frame * L + M - 1) / M);
        end
        summary();
    end

endmodule